// File: doc/BRIEF.md
# Operand Address Sequencer

This unit resolves where an instruction's operand lives. It receives an 8-bit opcode laid out as `aaabbbcc`, together with the address of the byte that follows the opcode and the two 8-bit index registers. The unit decodes the addressing mode from the `bbb` field, and the `cc` group decides what that field means. It then walks a byte-wide synchronous memory to build the 16-bit effective address. When the access is a load, it also fetches the operand.

A transfer begins with a one-cycle `start` pulse while the unit is idle. The unit issues at most one read per cycle. Read data comes back on the cycle after the request. When the work is finished, `done` rises for one cycle, and the effective address, the operand and the two flag outputs stay valid until the next accepted start. Accumulator-form opcodes finish without touching memory. So do opcode combinations that have no defined mode. Indirect modes dereference a two-byte pointer that always lies in page zero.

Top module: `addr_mode_seq`

## Requirements
- R1: For `cc`=01 (opcode bits 1:0), `bbb` (bits 4:2) selects 000 pre-indexed indirect `(zp,X)`, 001 zero page, 010 immediate, 011 absolute, 100 post-indexed indirect `(zp),Y`, 101 zero page X, 110 absolute Y, 111 absolute X. All eight are legal: `illegal` and `acc_mode` stay 0.
- R2: For `cc`=10, `bbb` 000 immediate, 001 zero page, 010 accumulator, 011 absolute, 101 zero page X, 111 absolute X. For `cc`=00 the same holds, except that 010 is not defined. The accumulator form issues no read and raises `done` with `acc_mode`=1 and `eff_addr`=0 on the first edge after start.
- R3: `cc`=11, `cc`=10 with `bbb` 100 or 110, and `cc`=00 with `bbb` 010, 100 or 110 are undefined. They issue no read and raise `done` with `illegal`=1 and `eff_addr`=0 on the first edge after start.
- R4: Immediate mode reports `eff_addr` equal to the operand pointer and the operand equal to the byte at that address.
- R5: Zero page gives `{0x00, b0}`. Zero page X gives `{0x00, (b0+X) mod 256}`, where b0 is the byte after the opcode.
- R6: Absolute operands sit low byte first at pointer and pointer+1. The indexed forms add X or Y as a full 16-bit sum, modulo 65536.
- R7: `(zp,X)` reads the pointer low byte from `(b0+X)&0xFF` and the high byte from `(b0+X+1)&0xFF`. The pointer is the effective address.
- R8: `(zp),Y` reads the pointer from `b0` and `(b0+1)&0xFF`, then adds Y as a full 16-bit sum.
- R9: With `is_store`=1, memory modes skip the operand read and report operand 0x00.
- R10: For memory modes, `done` rises on edge 2+N after the start edge (counting the start edge as 1), where N is the number of reads. N is 1 for immediate, 2 for zero page forms, 3 for absolute forms and 4 for indirect forms, minus one for a store in any non-immediate mode.
- R11: `done` lasts one cycle, and the outputs hold afterwards. A `start` while busy is ignored.
- R12: `mem_rd` is low whenever the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| opcode | input | 8 | Instruction byte `aaabbbcc` |
| oper_ptr | input | 16 | Address of the byte after the opcode |
| is_store | input | 1 | Access is a store: skip the operand read |
| x_idx | input | 8 | X index register |
| y_idx | input | 8 | Y index register |
| mem_rd | output | 1 | Read request this cycle |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 16 | Effective address |
| operand | output | 8 | Fetched operand (0 for stores and non-memory forms) |
| acc_mode | output | 1 | Accumulator form: no memory operand |
| illegal | output | 1 | Undefined mode combination |

## Verification
The corners that are hardest to reach are the pointer fetch at zero-page address 0xFF, which must wrap to 0x00 for the high byte, and the carries of indexed sums into the high byte or past 0xFFFF. Random memory contents almost never place a pointer there. The bench therefore uses a memory model that computes its bytes from the address, and it overrides a few chosen addresses so that directed runs land exactly on those wrap points. Random opcodes, indices and store flags then cover the decode tables and the latencies.

// File: rtl/amseq_pkg.sv
package amseq_pkg;

    typedef enum logic [3:0] {
        AM_IMM,
        AM_ZP,
        AM_ZPX,
        AM_ABS,
        AM_ABSX,
        AM_ABSY,
        AM_INDX,
        AM_INDY,
        AM_ACC,
        AM_BAD
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_BYTE0,
        ST_BYTE1,
        ST_PTRLO,
        ST_PTRHI,
        ST_OPER
    } seq_state_e;

endpackage

// File: rtl/amseq_decode.sv
module amseq_decode
    import amseq_pkg::*;
(
    input  logic [7:0] opcode,
    output amode_e     mode
);
    logic [1:0] grp;
    logic [2:0] sel;

    assign grp = opcode[1:0];
    assign sel = opcode[4:2];

    always_comb begin
        mode = AM_BAD;
        case (grp)
            2'b01: begin
                case (sel)
                    3'd0: mode = AM_INDX;
                    3'd1: mode = AM_ZP;
                    3'd2: mode = AM_IMM;
                    3'd3: mode = AM_ABS;
                    3'd4: mode = AM_INDY;
                    3'd5: mode = AM_ZPX;
                    3'd6: mode = AM_ABSY;
                    default: mode = AM_ABSX;
                endcase
            end
            2'b10: begin
                case (sel)
                    3'd0: mode = AM_IMM;
                    3'd1: mode = AM_ZP;
                    3'd2: mode = AM_ACC;
                    3'd3: mode = AM_ABS;
                    3'd5: mode = AM_ZPX;
                    3'd7: mode = AM_ABSX;
                    default: mode = AM_BAD;
                endcase
            end
            2'b00: begin
                case (sel)
                    3'd0: mode = AM_IMM;
                    3'd1: mode = AM_ZP;
                    3'd3: mode = AM_ABS;
                    3'd5: mode = AM_ZPX;
                    3'd7: mode = AM_ABSX;
                    default: mode = AM_BAD;
                endcase
            end
            default: mode = AM_BAD;
        endcase
    end
endmodule

// File: rtl/amseq_index_add.sv
module amseq_index_add #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] idx,
    input  logic              page_wrap,
    output logic [ADDR_W-1:0] sum
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] low_sum;
    logic [ADDR_W-1:0] full_sum;

    assign low_sum  = base[DATA_W-1:0] + idx;
    assign full_sum = base + {{HI_W{1'b0}}, idx};
    assign sum      = page_wrap ? {{HI_W{1'b0}}, low_sum} : full_sum;

    always_comb begin
        if (page_wrap)
            a_r5_page_high_zero: assert (sum[ADDR_W-1:DATA_W] == '0);
    end
endmodule

// File: rtl/addr_mode_seq.sv
module addr_mode_seq
    import amseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] oper_ptr,
    input  logic              is_store,
    input  logic [DATA_W-1:0] x_idx,
    input  logic [DATA_W-1:0] y_idx,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [DATA_W-1:0] operand,
    output logic              acc_mode,
    output logic              illegal
);
    localparam int HI_W = ADDR_W - DATA_W;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        seq_state_e        st;
        amode_e            mode;
        logic              store;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] b0;
        logic [DATA_W-1:0] zpp;
        logic [ADDR_W-1:0] ea;
        logic [DATA_W-1:0] oper;
        logic              done;
        logic              acc;
        logic              bad;
    } seq_t;

    seq_t   seq_q, seq_d;
    amode_e dec_mode;

    logic [ADDR_W-1:0] add_base, add_sum, ptr_next;
    logic [DATA_W-1:0] add_idx;
    logic              add_wrap;

    amseq_decode u_decode (
        .opcode (opcode),
        .mode   (dec_mode)
    );

    amseq_index_add #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ea_add (
        .base      (add_base),
        .idx       (add_idx),
        .page_wrap (add_wrap),
        .sum       (add_sum)
    );

    amseq_index_add #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr_inc (
        .base      (seq_q.ptr),
        .idx       (ONE),
        .page_wrap (1'b0),
        .sum       (ptr_next)
    );

    // adder operand selection per step
    always_comb begin
        add_base = '0;
        add_idx  = '0;
        add_wrap = 1'b0;
        case (seq_q.st)
            ST_BYTE0: begin
                add_base = {{HI_W{1'b0}}, mem_rdata};
                add_wrap = 1'b1;
                if (seq_q.mode == AM_ZPX || seq_q.mode == AM_INDX)
                    add_idx = seq_q.x;
            end
            ST_BYTE1: begin
                add_base = {mem_rdata, seq_q.b0};
                if (seq_q.mode == AM_ABSX)      add_idx = seq_q.x;
                else if (seq_q.mode == AM_ABSY) add_idx = seq_q.y;
            end
            ST_PTRLO: begin
                add_base = {{HI_W{1'b0}}, seq_q.zpp};
                add_idx  = ONE;
                add_wrap = 1'b1;
            end
            ST_PTRHI: begin
                add_base = {mem_rdata, seq_q.b0};
                if (seq_q.mode == AM_INDY) add_idx = seq_q.y;
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        mem_rd     = 1'b0;
        mem_addr   = '0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.mode  = dec_mode;
                    seq_d.store = is_store;
                    seq_d.x     = x_idx;
                    seq_d.y     = y_idx;
                    seq_d.ptr   = oper_ptr;
                    seq_d.oper  = '0;
                    seq_d.ea    = '0;
                    seq_d.acc   = 1'b0;
                    seq_d.bad   = 1'b0;
                    if (dec_mode == AM_ACC) begin
                        seq_d.acc  = 1'b1;
                        seq_d.done = 1'b1;
                    end else if (dec_mode == AM_BAD) begin
                        seq_d.bad  = 1'b1;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                mem_rd   = 1'b1;
                mem_addr = seq_q.ptr;
                seq_d.st = ST_BYTE0;
            end
            ST_BYTE0: begin
                seq_d.b0 = mem_rdata;
                case (seq_q.mode)
                    AM_IMM: begin
                        seq_d.ea   = seq_q.ptr;
                        seq_d.oper = mem_rdata;
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                    AM_ZP, AM_ZPX: begin
                        seq_d.ea = add_sum;
                        if (seq_q.store) begin
                            seq_d.st   = ST_IDLE;
                            seq_d.done = 1'b1;
                        end else begin
                            mem_rd   = 1'b1;
                            mem_addr = add_sum;
                            seq_d.st = ST_OPER;
                        end
                    end
                    AM_INDX, AM_INDY: begin
                        seq_d.zpp = add_sum[DATA_W-1:0];
                        mem_rd    = 1'b1;
                        mem_addr  = add_sum;
                        seq_d.st  = ST_PTRLO;
                    end
                    default: begin
                        mem_rd   = 1'b1;
                        mem_addr = ptr_next;
                        seq_d.st = ST_BYTE1;
                    end
                endcase
            end
            ST_BYTE1, ST_PTRHI: begin
                seq_d.ea = add_sum;
                if (seq_q.store) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    mem_rd   = 1'b1;
                    mem_addr = add_sum;
                    seq_d.st = ST_OPER;
                end
            end
            ST_PTRLO: begin
                seq_d.b0 = mem_rdata;
                mem_rd   = 1'b1;
                mem_addr = add_sum;
                seq_d.st = ST_PTRHI;
            end
            ST_OPER: begin
                seq_d.oper = mem_rdata;
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.mode <= AM_IMM;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign done     = seq_q.done;
    assign eff_addr = seq_q.ea;
    assign operand  = seq_q.oper;
    assign acc_mode = seq_q.acc;
    assign illegal  = seq_q.bad;

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE) |-> !mem_rd);

    a_r3_bad_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && start && dec_mode == AM_BAD)
            |=> (done && illegal && !mem_rd && eff_addr == '0));

    a_r2_acc_quick: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && start && dec_mode == AM_ACC)
            |=> (done && acc_mode && !mem_rd));

    a_r7_ptr_in_page0: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_PTRLO ||
         (seq_q.st == ST_BYTE0 && (seq_q.mode == AM_INDX || seq_q.mode == AM_INDY)))
            |-> (mem_rd && mem_addr[ADDR_W-1:DATA_W] == '0));

    a_r5_zp_result_page0: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (seq_q.mode == AM_ZP || seq_q.mode == AM_ZPX))
            |-> (eff_addr[ADDR_W-1:DATA_W] == '0));

    a_r9_store_skips_oper: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_OPER) |-> !seq_q.store);

    a_r11_busy_holds_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE && start) |=> $stable(seq_q.mode));
endmodule

// File: tb/sim_addr_mode_seq.sv
module sim_addr_mode_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] oper_ptr = '0;
    logic        is_store = 1'b0;
    logic [7:0]  x_idx = '0, y_idx = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic [15:0] eff_addr;
    logic [7:0]  operand;
    logic        acc_mode, illegal;

    int n_chk = 0, n_fail = 0, rd_cnt = 0;
    logic [15:0] ov_addr [4];
    logic [7:0]  ov_data [4];
    logic [7:0]  salt = 8'h5A;

    always #10 clk = ~clk;

    addr_mode_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .oper_ptr(oper_ptr), .is_store(is_store), .x_idx(x_idx), .y_idx(y_idx),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .eff_addr(eff_addr), .operand(operand),
        .acc_mode(acc_mode), .illegal(illegal)
    );

    function automatic logic [7:0] mv(input logic [15:0] a);
        logic [7:0] h;
        for (int i = 0; i < 4; i++)
            if (ov_addr[i] == a) return ov_data[i];
        h = a[15:8] * 8'd59;
        return a[7:0] ^ h ^ salt;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mv(mem_addr);
            rd_cnt    <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_ov();
        for (int i = 0; i < 4; i++) begin
            ov_addr[i] = 16'h0F0F + 16'(i);
            ov_data[i] = 8'h00;
        end
    endtask

    // kind: 0 imm 1 zp 2 zpx 3 abs 4 absx 5 absy 6 indx 7 indy 8 acc 9 undefined
    function automatic int kind_of(input logic [7:0] op);
        logic [2:0] b;
        b = op[4:2];
        if (op[1:0] == 2'b01) begin
            if (b == 0) return 6;
            if (b == 1) return 1;
            if (b == 2) return 0;
            if (b == 3) return 3;
            if (b == 4) return 7;
            if (b == 5) return 2;
            if (b == 6) return 5;
            return 4;
        end
        if (op[1:0] == 2'b11) return 9;
        if (b == 0) return 0;
        if (b == 1) return 1;
        if (b == 3) return 3;
        if (b == 5) return 2;
        if (b == 7) return 4;
        if (b == 2 && op[1:0] == 2'b10) return 8;
        return 9;
    endfunction

    task automatic run_one(input logic [7:0] op, input logic [15:0] p,
                           input logic [7:0] xv, input logic [7:0] yv,
                           input bit st, input bit hold_start);
        int k, nrd, lat;
        logic [7:0] b0, b1, lo, hi, pz;
        logic [15:0] e_ea;
        logic [7:0] e_op;
        string rq;
        logic [15:0] ea_seen;
        logic [7:0] op_seen;
        k = kind_of(op);
        b0 = mv(p);
        b1 = mv(p + 16'd1);
        e_ea = 16'h0; e_op = 8'h00; nrd = 0; rq = "R3";
        case (k)
            0: begin e_ea = p; e_op = b0; nrd = 1; rq = "R4"; end
            1: begin e_ea = {8'h00, b0}; nrd = 2; rq = "R5"; end
            2: begin e_ea = {8'h00, 8'(b0 + xv)}; nrd = 2; rq = "R5"; end
            3, 4, 5: begin
                e_ea = {b1, b0} + ((k == 4) ? {8'h00, xv} : (k == 5) ? {8'h00, yv} : 16'h0);
                nrd = 3; rq = "R6";
            end
            6: begin
                pz = b0 + xv; lo = mv({8'h00, pz}); hi = mv({8'h00, 8'(pz + 8'd1)});
                e_ea = {hi, lo}; nrd = 4; rq = "R7";
            end
            7: begin
                lo = mv({8'h00, b0}); hi = mv({8'h00, 8'(b0 + 8'd1)});
                e_ea = {hi, lo} + {8'h00, yv}; nrd = 4; rq = "R8";
            end
            8: rq = "R2";
            default: rq = "R3";
        endcase
        if (k >= 1 && k <= 7) begin
            if (st) nrd = nrd - 1;
            else e_op = mv(e_ea);
        end
        @(negedge clk);
        opcode = op; oper_ptr = p; x_idx = xv; y_idx = yv; is_store = st;
        start = 1'b1; rd_cnt = 0; lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (!hold_start) start = 1'b0;
            else begin
                opcode = 8'h0A; x_idx = ~xv; oper_ptr = ~p; // would finish at once if accepted
            end
        end while (!done && lat < 20);
        start = 1'b0;
        chk(eff_addr == e_ea, rq, "eff_addr", eff_addr, e_ea);
        chk(operand == e_op, (st && k >= 1 && k <= 7) ? "R9" : rq, "operand", operand, e_op);
        chk(acc_mode == (k == 8), "R2", "acc_mode", acc_mode, (k == 8));
        chk(illegal == (k == 9), "R3", "illegal", illegal, (k == 9));
        if (op[1:0] == 2'b01)
            chk(!illegal && !acc_mode, "R1", "group01 legal", {illegal, acc_mode}, 0);
        chk(lat == ((k >= 8) ? 1 : nrd + 2), (k >= 8) ? rq : "R10", "latency", lat,
            (k >= 8) ? 1 : nrd + 2);
        chk(rd_cnt == nrd, "R10", "read count", rd_cnt, nrd);
        ea_seen = eff_addr; op_seen = operand;
        @(negedge clk);
        chk(!done, "R11", "done width", done, 0);
        chk(eff_addr == ea_seen && operand == op_seen, "R11", "hold",
            {eff_addr, operand}, {ea_seen, op_seen});
        chk(!mem_rd, "R12", "idle read", mem_rd, 0);
    endtask

    initial begin
        #(64'd20 * 64'd200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_ov();
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(!done && !mem_rd && eff_addr == 0 && !illegal && !acc_mode, "R12", "reset state",
            {done, mem_rd, illegal, acc_mode}, 0);
        // R1/R2/R3 decode sweep over fixed cases
        run_one(8'h0A, 16'h4000, 8'h11, 8'h22, 1'b0, 1'b0); // cc=10 bbb=010 acc
        run_one(8'h08, 16'h4000, 8'h11, 8'h22, 1'b0, 1'b0); // cc=00 bbb=010 undefined
        run_one(8'h03, 16'h4000, 8'h11, 8'h22, 1'b0, 1'b0); // cc=11
        run_one(8'h12, 16'h4000, 8'h11, 8'h22, 1'b0, 1'b0); // cc=10 bbb=100 undefined
        // R5 zp,X wrap
        clear_ov(); ov_addr[0] = 16'h8000; ov_data[0] = 8'hF0;
        run_one(8'h15, 16'h8000, 8'h20, 8'h00, 1'b0, 1'b0);
        // R6 absolute X carry into high byte
        clear_ov(); ov_addr[0] = 16'h8000; ov_data[0] = 8'hFF;
        ov_addr[1] = 16'h8001; ov_data[1] = 8'h12;
        run_one(8'h1D, 16'h8000, 8'h01, 8'h00, 1'b0, 1'b0);
        // R6 absolute Y wrap past 0xFFFF, store
        ov_data[1] = 8'hFF;
        run_one(8'h19, 16'h8000, 8'h00, 8'h02, 1'b1, 1'b0);
        // R6 operand pointer crossing a page for its high byte
        clear_ov();
        run_one(8'h0D, 16'h80FF, 8'h00, 8'h00, 1'b0, 1'b0);
        // R7 (zp,X) pointer at 0xFF wraps high byte to 0x00
        clear_ov(); ov_addr[0] = 16'h8000; ov_data[0] = 8'hF7;
        ov_addr[1] = 16'h00FF; ov_data[1] = 8'h34;
        ov_addr[2] = 16'h0000; ov_data[2] = 8'h56;
        run_one(8'h01, 16'h8000, 8'h08, 8'h00, 1'b0, 1'b0);
        // R8 (zp),Y pointer at 0xFF plus carry
        ov_data[0] = 8'hFF; ov_data[1] = 8'hF0;
        run_one(8'h11, 16'h8000, 8'h00, 8'h20, 1'b0, 1'b0);
        run_one(8'h11, 16'h8000, 8'h00, 8'h20, 1'b1, 1'b0); // R9 store
        // R11 start held high while busy
        run_one(8'h01, 16'h8000, 8'h08, 8'h00, 1'b0, 1'b1);
        run_one(8'h09, 16'h8000, 8'h00, 8'h00, 1'b0, 1'b0); // R4 immediate
        clear_ov();
        for (int i = 0; i < 150; i++) begin
            salt = 8'($urandom);
            run_one(8'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                    1'($urandom), (i % 10) == 3);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule